// File: doc/BRIEF.md
# Dual-Expiration Window Watchdog

This block is a two-stage watchdog for a processor subsystem. A 32-bit timebase counts every clock cycle from reset, whether or not the watchdog is running, and software can read it at any time. A separate watchdog counter runs only while the watchdog is active. Its expiry period is 2^N cycles, where N is the build-time interval width and may be 8 to 32.

When the watchdog counter expires for the first time, the block sends a one-cycle interrupt and raises a warning bit. Software answers by writing a one to that bit. If the bit is still set when the next expiry arrives, the block drives a fixed-length reset pulse and sets a sticky flag. Software can read that flag after the system recovers.

Starting the watchdog takes two arm bits held in two different registers. Stopping it takes clearing both of them. A build-time lock option makes the watchdog impossible to stop once it has started. Registers are reached over a simple request bus that accepts one request per cycle and returns read data one cycle later.

Top module: `dual_stage_watchdog`

## Requirements
- R1: The timebase is a 32-bit counter. Reset sets it to zero and it then rises by one every cycle, whether the watchdog is active or not. A read of offset 0x8 returns the count. The difference between two reads equals the number of cycles between the edges that accepted them.
- R2: After reset, irq and wd_reset are low and offsets 0x0 and 0x4 read zero. The watchdog becomes active only when both arm bits are 1: bit 0 of offset 0x0 and bit 0 of offset 0x4. With only one arm bit set, no interrupt is ever raised.
- R3: The watchdog counter starts at zero when the watchdog becomes active, and it expires every 2^N active cycles. On an expiry while the warning bit (bit 3 of offset 0x0) is clear, the block sets the warning bit and drives irq high for exactly one cycle. irq is high in the cycle after the clock edge that comes 2^N+1 edges after the edge that accepted the enabling write.
- R4: Writing 1 to bit 3 of offset 0x0 clears the warning bit. Writing 0 to it leaves the bit unchanged.
- R5: On an expiry while the warning bit is set, wd_reset rises 2^N cycles after the preceding interrupt and stays high for exactly RST_CYCLES cycles (16 by default). The same expiry sets the sticky reset flag (bit 2 of offset 0x0) and clears the warning bit.
- R6: Clearing the warning bit before the next expiry prevents the reset. It does not restart the watchdog counter, so the next interrupt comes 2^N cycles after the previous one.
- R7: The sticky reset flag stays set until software writes 1 to bit 2 of offset 0x0.
- R8: With LOCK_ONCE=0, clearing only one arm bit leaves the watchdog running. Once both arm bits are clear, the watchdog stops and raises no interrupt or reset. Enabling it again restarts the watchdog counter from zero.
- R9: With LOCK_ONCE=1, once the watchdog is active, writes of 0 to either arm bit are ignored, and both bits read back as 1.
- R10: req_ready is always high. A read accepted on one edge gives rsp_valid high with its data on the next edge and at no other time. Writes to offset 0x8 have no effect, and reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Bus request accepted (always high) |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 4 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | One-cycle first-stage expiry interrupt |
| wd_reset | output | 1 | Second-stage reset pulse |

## Verification
On every cycle, the assertions check the following:
- the timebase steps by one;
- irq lasts a single cycle and only follows an active, unwarned expiry;
- each reset pulse lasts exactly RST_CYCLES and sets the sticky flag;
- read responses are timed correctly;
- the lock never lets an active watchdog stop.

Only the bench scenarios can show the rest:
- the exact 2^N expiry spacing;
- that clearing the warning bit leaves the counter phase unchanged while writing zero changes nothing;
- the hysteresis between the two arm bits, including the restart from zero after re-enabling;
- the write-one-to-clear behaviour of the sticky flag.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int TB_W   = 32;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_ARM  = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_TIME = 4'h8;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_RST_BIT  = 2;
    localparam int CTRL_WARN_BIT = 3;
    localparam int ARM_EN_BIT    = 0;

    typedef enum logic {
        PH_QUIET  = 1'b0,
        PH_WARNED = 1'b1
    } wd_phase_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic wr_ctrl;
        logic wr_arm;
        logic warn_clr;
        logic sts_clr;
        logic arm_bit;
    } reg_cmd_t;

    function automatic logic interval_ok(int n);
        return (n >= 8) && (n <= 32);
    endfunction

    function automatic reg_cmd_t decode_write(bus_req_t r);
        reg_cmd_t c;
        logic     wr;
        wr         = r.valid && r.write;
        c.wr_ctrl  = wr && (r.addr == OFS_CTRL);
        c.wr_arm   = wr && (r.addr == OFS_ARM);
        c.warn_clr = c.wr_ctrl && r.wdata[CTRL_WARN_BIT];
        c.sts_clr  = c.wr_ctrl && r.wdata[CTRL_RST_BIT];
        c.arm_bit  = c.wr_ctrl ? r.wdata[CTRL_EN_BIT] : r.wdata[ARM_EN_BIT];
        return c;
    endfunction

endpackage

// File: rtl/wdg_timebase.sv
module wdg_timebase #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    output logic [WIDTH-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count + 1'b1;
    end
endmodule

// File: rtl/wdg_expiry.sv
module wdg_expiry #(
    parameter int INTERVAL_BITS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic expire
);
    logic [INTERVAL_BITS-1:0] wd_cnt;

    // Carry out of the top interval bit marks an expiry; N=32 is a full wrap.
    always_ff @(posedge clk) begin
        if (rst || !active) wd_cnt <= '0;
        else                wd_cnt <= wd_cnt + 1'b1;
    end

    assign expire = active && (&wd_cnt);
endmodule

// File: rtl/wdg_enable.sv
module wdg_enable #(
    parameter bit LOCK_ONCE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_ctrl,
    input  logic wr_arm,
    input  logic arm_bit,
    output logic en_ctrl,
    output logic en_arm,
    output logic active
);
    logic locked;
    logic active_nx;

    assign locked = LOCK_ONCE && active;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_ctrl <= 1'b0;
            en_arm  <= 1'b0;
        end else begin
            if (wr_ctrl && (arm_bit || !locked)) en_ctrl <= arm_bit;
            if (wr_arm  && (arm_bit || !locked)) en_arm  <= arm_bit;
        end
    end

    // Hysteresis: start needs both arm bits, stop needs both cleared.
    always_comb begin
        active_nx = active;
        if (en_ctrl && en_arm)              active_nx = 1'b1;
        else if (!en_ctrl && !en_arm && !locked) active_nx = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) active <= 1'b0;
        else     active <= active_nx;
    end
endmodule

// File: rtl/wdg_stage.sv
module wdg_stage #(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic warn_clr,
    input  logic sts_clr,
    output logic warn,
    output logic rst_sts,
    output logic irq,
    output logic wd_reset
);
    import wdg_pkg::*;

    localparam int PW = $clog2(RST_CYCLES + 1);

    wd_phase_e      phase;
    logic [PW-1:0]  pulse_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_QUIET;
            rst_sts    <= 1'b0;
            irq        <= 1'b0;
            pulse_left <= '0;
        end else begin
            irq <= expire && (phase == PH_QUIET);
            if (pulse_left != '0) pulse_left <= pulse_left - 1'b1;
            if (expire) begin
                if (phase == PH_WARNED) begin
                    phase      <= PH_QUIET;
                    rst_sts    <= 1'b1;
                    pulse_left <= PW'(RST_CYCLES);
                end else begin
                    phase <= PH_WARNED;
                end
            end else if (warn_clr) begin
                phase <= PH_QUIET;
            end
            if (sts_clr && !(expire && phase == PH_WARNED)) rst_sts <= 1'b0;
        end
    end

    assign warn     = (phase == PH_WARNED);
    assign wd_reset = (pulse_left != '0);
endmodule

// File: rtl/dual_stage_watchdog.sv
module dual_stage_watchdog #(
    parameter int INTERVAL_BITS = 8,
    parameter bit LOCK_ONCE     = 1'b0,
    parameter int RST_CYCLES    = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [3:0]  req_addr,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        irq,
    output logic        wd_reset
);
    import wdg_pkg::*;

    bus_req_t          req;
    reg_cmd_t          cmd;
    logic [TB_W-1:0]   tb_count;
    logic              en_ctrl, en_arm, wd_active, expire;
    logic              warn_bit, rst_sts;
    logic [DATA_W-1:0] rd_mux;

    assign req       = '{valid: req_valid, write: req_write, addr: req_addr, wdata: req_wdata};
    assign cmd       = decode_write(req);
    assign req_ready = 1'b1;

    wdg_timebase #(.WIDTH(TB_W)) u_timebase (
        .clk(clk), .rst(rst), .count(tb_count)
    );

    wdg_enable #(.LOCK_ONCE(LOCK_ONCE)) u_enable (
        .clk(clk), .rst(rst),
        .wr_ctrl(cmd.wr_ctrl), .wr_arm(cmd.wr_arm), .arm_bit(cmd.arm_bit),
        .en_ctrl(en_ctrl), .en_arm(en_arm), .active(wd_active)
    );

    wdg_expiry #(.INTERVAL_BITS(INTERVAL_BITS)) u_expiry (
        .clk(clk), .rst(rst), .active(wd_active), .expire(expire)
    );

    wdg_stage #(.RST_CYCLES(RST_CYCLES)) u_stage (
        .clk(clk), .rst(rst), .expire(expire),
        .warn_clr(cmd.warn_clr), .sts_clr(cmd.sts_clr),
        .warn(warn_bit), .rst_sts(rst_sts), .irq(irq), .wd_reset(wd_reset)
    );

    always_comb begin
        rd_mux = '0;
        case (req.addr)
            OFS_CTRL: begin
                rd_mux[CTRL_EN_BIT]   = en_ctrl;
                rd_mux[CTRL_RST_BIT]  = rst_sts;
                rd_mux[CTRL_WARN_BIT] = warn_bit;
            end
            OFS_ARM:  rd_mux[ARM_EN_BIT] = en_arm;
            OFS_TIME: rd_mux = DATA_W'(tb_count);
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req.valid && !req.write;
            if (req.valid && !req.write) rsp_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
    parameter bit LOCK_ONCE  = 1'b0,
    parameter int RST_CYCLES = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_write,
    input logic        rsp_valid,
    input logic        irq,
    input logic        wd_reset,
    input logic        active,
    input logic        warn,
    input logic        rst_sts,
    input logic [31:0] tb_count
);
    logic [31:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)           run_len <= '0;
        else if (wd_reset) run_len <= run_len + 1'b1;
        else               run_len <= '0;
    end

    assert_timebase_step_R1: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> tb_count == $past(tb_count) + 32'd1);

    assert_irq_single_R3: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    assert_irq_from_active_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(active) && warn);

    assert_pulse_bound_R5: assert property (@(posedge clk) disable iff (rst)
        wd_reset |-> run_len < RST_CYCLES);

    assert_pulse_length_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(wd_reset) |-> run_len == RST_CYCLES);

    assert_reset_sets_flag_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(wd_reset) |-> rst_sts && !warn);

    assert_lock_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (LOCK_ONCE && $past(active) && !$past(rst)) |-> active);

    assert_read_resp_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);

    assert_no_spurious_resp_R10: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> !rsp_valid);
endmodule

bind dual_stage_watchdog wdg_checker #(.LOCK_ONCE(LOCK_ONCE), .RST_CYCLES(RST_CYCLES)) u_wdg_checker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .rsp_valid(rsp_valid), .irq(irq), .wd_reset(wd_reset),
    .active(wd_active), .warn(warn_bit), .rst_sts(rst_sts), .tb_count(tb_count)
);

// File: tb/test_dual_stage_watchdog.sv
module test_dual_stage_watchdog;

    localparam int N      = 8;
    localparam int PERIOD = 1 << N;
    localparam int RSTLEN = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid [2];
    logic        req_write [2];
    logic [3:0]  req_addr  [2];
    logic [31:0] req_wdata [2];
    logic        req_ready [2];
    logic        rsp_valid [2];
    logic [31:0] rsp_rdata [2];
    logic        irq       [2];
    logic        wd_reset  [2];

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dual_stage_watchdog #(.INTERVAL_BITS(N), .LOCK_ONCE(1'b0), .RST_CYCLES(RSTLEN)) i_dual_stage_watchdog (
        .clk(clk), .rst(rst), .req_valid(req_valid[0]), .req_ready(req_ready[0]),
        .req_write(req_write[0]), .req_addr(req_addr[0]), .req_wdata(req_wdata[0]),
        .rsp_valid(rsp_valid[0]), .rsp_rdata(rsp_rdata[0]), .irq(irq[0]), .wd_reset(wd_reset[0])
    );

    dual_stage_watchdog #(.INTERVAL_BITS(N), .LOCK_ONCE(1'b1), .RST_CYCLES(RSTLEN)) i_dual_stage_watchdog_lock (
        .clk(clk), .rst(rst), .req_valid(req_valid[1]), .req_ready(req_ready[1]),
        .req_write(req_write[1]), .req_addr(req_addr[1]), .req_wdata(req_wdata[1]),
        .rsp_valid(rsp_valid[1]), .rsp_rdata(rsp_rdata[1]), .irq(irq[1]), .wd_reset(wd_reset[1])
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic apply_reset();
        rst = 1'b1;
        for (int d = 0; d < 2; d++) begin
            req_valid[d] = 1'b0; req_write[d] = 1'b0;
            req_addr[d] = '0;    req_wdata[d] = '0;
        end
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic bus_write(input int d, input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        req_valid[d] = 1'b1; req_write[d] = 1'b1; req_addr[d] = a; req_wdata[d] = v;
        @(posedge clk);
        #1 req_valid[d] = 1'b0; req_write[d] = 1'b0;
    endtask

    task automatic bus_read(input int d, input logic [3:0] a, output logic [31:0] v, output int at);
        @(negedge clk);
        req_valid[d] = 1'b1; req_write[d] = 1'b0; req_addr[d] = a;
        chk(req_ready[d] == 1'b1, "R10", "req_ready", req_ready[d], 1);
        @(posedge clk);
        at = cyc;
        #1 req_valid[d] = 1'b0;
        @(negedge clk);
        chk(rsp_valid[d] == 1'b1, "R10", "rsp_valid after read", rsp_valid[d], 1);
        v = rsp_rdata[d];
        @(negedge clk);
        chk(rsp_valid[d] == 1'b0, "R10", "rsp_valid one cycle", rsp_valid[d], 0);
    endtask

    task automatic expect_reg(input int d, input logic [3:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        int at;
        bus_read(d, a, v, at);
        chk(v == exp, req, $sformatf("read 0x%0h", a), v, exp);
    endtask

    // Waits for irq; also counts cycles with wd_reset high on the way.
    task automatic wait_irq(input int d, input int limit, output int at, output int rst_seen);
        at = -1; rst_seen = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (wd_reset[d]) rst_seen++;
            if (irq[d]) begin at = cyc; break; end
        end
    endtask

    task automatic t_reset_state();
        logic [31:0] t0, t1;
        int a0, a1;
        apply_reset();
        @(negedge clk);
        chk(irq[0] == 0 && wd_reset[0] == 0, "R2", "outputs after reset", {irq[0], wd_reset[0]}, 0);
        expect_reg(0, 4'h0, 32'h0, "R2");
        expect_reg(0, 4'h4, 32'h0, "R2");
        expect_reg(0, 4'hC, 32'h0, "R10");
        bus_read(0, 4'h8, t0, a0);
        bus_write(0, 4'h8, 32'h0);
        repeat (7) @(negedge clk);
        bus_read(0, 4'h8, t1, a1);
        chk(t1 - t0 == 32'(a1 - a0), "R1", "timebase delta", t1 - t0, a1 - a0);
        chk(t1 - t0 == 32'(a1 - a0), "R10", "write to 0x8 ignored", t1 - t0, a1 - a0);
    endtask

    task automatic t_single_arm();
        int at, rs;
        logic [31:0] t0, t1;
        int a0, a1;
        apply_reset();
        bus_write(0, 4'h0, 32'h1);
        bus_read(0, 4'h8, t0, a0);
        wait_irq(0, 3 * PERIOD, at, rs);
        chk(at == -1, "R2", "no irq with one arm bit", at, -1);
        bus_read(0, 4'h8, t1, a1);
        chk(t1 - t0 == 32'(a1 - a0), "R1", "timebase runs while idle", t1 - t0, a1 - a0);
        expect_reg(0, 4'h0, 32'h1, "R2");
    endtask

    task automatic t_first_expiry();
        int e, at, at2, rs;
        apply_reset();
        bus_write(0, 4'h4, 32'h1);
        bus_write(0, 4'h0, 32'h1);
        e = cyc;
        wait_irq(0, 2 * PERIOD, at, rs);
        chk(at == e + PERIOD + 1, "R3", "first irq cycle", at, e + PERIOD + 1);
        @(negedge clk);
        chk(irq[0] == 1'b0, "R3", "irq one cycle", irq[0], 0);
        expect_reg(0, 4'h0, 32'h9, "R3");
        bus_write(0, 4'h0, 32'h1);
        expect_reg(0, 4'h0, 32'h9, "R4");
        bus_write(0, 4'h0, 32'h9);
        expect_reg(0, 4'h0, 32'h1, "R4");
        wait_irq(0, 2 * PERIOD, at2, rs);
        chk(at2 == at + PERIOD, "R6", "irq spacing after clear", at2, at + PERIOD);
        chk(rs == 0, "R6", "no reset after clear", rs, 0);
    endtask

    task automatic t_second_expiry();
        int e, at, rs, rise, len, at3;
        apply_reset();
        bus_write(0, 4'h0, 32'h1);
        bus_write(0, 4'h4, 32'h1);
        e = cyc;
        wait_irq(0, 2 * PERIOD, at, rs);
        rise = -1;
        for (int i = 0; i < 2 * PERIOD; i++) begin
            @(negedge clk);
            if (wd_reset[0]) begin rise = cyc; break; end
        end
        chk(rise == at + PERIOD, "R5", "reset rise cycle", rise, at + PERIOD);
        len = 0;
        while (wd_reset[0] && len < 4 * RSTLEN) begin
            len++;
            @(negedge clk);
        end
        chk(len == RSTLEN, "R5", "reset pulse length", len, RSTLEN);
        expect_reg(0, 4'h0, 32'h5, "R5");
        repeat (20) @(negedge clk);
        expect_reg(0, 4'h0, 32'h5, "R7");
        bus_write(0, 4'h0, 32'h5);
        expect_reg(0, 4'h0, 32'h1, "R7");
        wait_irq(0, 2 * PERIOD, at3, rs);
        chk(at3 == at + 2 * PERIOD, "R5", "irq after reset restarts stage", at3, at + 2 * PERIOD);
    endtask

    task automatic t_disable();
        int e, at, rs, e2;
        apply_reset();
        bus_write(0, 4'h0, 32'h1);
        bus_write(0, 4'h4, 32'h1);
        e = cyc;
        repeat (50) @(negedge clk);
        bus_write(0, 4'h0, 32'h0);
        wait_irq(0, 2 * PERIOD, at, rs);
        chk(at == e + PERIOD + 1, "R8", "one arm bit keeps running", at, e + PERIOD + 1);
        bus_write(0, 4'h4, 32'h0);
        bus_write(0, 4'h0, 32'h8);
        expect_reg(0, 4'h4, 32'h0, "R8");
        wait_irq(0, 3 * PERIOD, at, rs);
        chk(at == -1 && rs == 0, "R8", "no irq or reset when stopped", at, -1);
        bus_write(0, 4'h0, 32'h1);
        bus_write(0, 4'h4, 32'h1);
        e2 = cyc;
        wait_irq(0, 2 * PERIOD, at, rs);
        chk(at == e2 + PERIOD + 1, "R8", "counter restart on re-enable", at, e2 + PERIOD + 1);
    endtask

    task automatic t_lock();
        int e, at, rs;
        apply_reset();
        bus_write(1, 4'h0, 32'h1);
        bus_write(1, 4'h4, 32'h1);
        e = cyc;
        repeat (3) @(negedge clk);
        bus_write(1, 4'h0, 32'h0);
        bus_write(1, 4'h4, 32'h0);
        expect_reg(1, 4'h0, 32'h1, "R9");
        expect_reg(1, 4'h4, 32'h1, "R9");
        wait_irq(1, 2 * PERIOD, at, rs);
        chk(at == e + PERIOD + 1, "R9", "locked watchdog keeps running", at, e + PERIOD + 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired: actual %0d expected %0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_single_arm();
        t_first_expiry();
        t_second_expiry();
        t_disable();
        t_lock();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule